// File: doc/BRIEF.md
# Write-Protection Status Register Controller

This block keeps the protection state of a small programmable device: a write-enable latch, a register-write-enable latch and a two-bit block-lock code, all held in one byte-wide status register. The bus front end hands it already-decoded register write and register read strobes with their data. The block returns one byte per read and steps through a short unlock sequence on writes.

From the latches, the block-lock code and a write-protect input pin, the block decides combinationally whether a requested write may proceed. A request names one of five kinds: volatile potentiometer write, nonvolatile potentiometer write, memory-array write with a target address, volatile status-bit write or nonvolatile status-bit write. The decision separates volatile targets from nonvolatile ones. The locked memory region is an upper address range chosen by the block-lock code.

Top module: `wp_stat_ctrl`

## Requirements
- R1: After reset the enable latches and block-lock bits are all 0, and a register read returns 00h.
- R2: A register write of 02h sets the write-enable latch (bit 1). A read strobe yields the register byte on rd_data_o, with rd_vld_o high, in the cycle after the strobe.
- R3: A register write of 06h sets the register-write-enable latch (bit 2) only when the write-enable latch is already 1. Otherwise the write changes nothing.
- R4: While the register-write-enable latch is 1, the next register write loads block-lock bits 1:0 from data bits 4:3 and the write-enable latch from data bit 1, and clears the register-write-enable latch. The sequence 02h, 06h, 02h therefore leaves both block-lock bits 0.
- R5: While wp_i is 1, that loading write leaves the block-lock bits unchanged but still updates both latches.
- R6: A read returns {000, BL1, BL0, RWEL, WEL, 0}: bits 7:5 and bit 0 always read 0. A read leaves all state unchanged, so a pending unlock survives it.
- R7: Request kinds 0 (volatile potentiometer), 1 (nonvolatile potentiometer) and 2 (memory) are never permitted while the write-enable latch is 0.
- R8: Request kinds 3 (volatile status bits) and 4 (nonvolatile status bits) are never permitted while the register-write-enable latch is 0.
- R9: Kind 0 is permitted only when the block-lock code is 00, whatever wp_i is. Kind 1 is permitted only when the code is 00 and wp_i is 0.
- R10: Kind 2 is denied while wp_i is 1. With wp_i 0 it is denied when the address lies in the locked range: code 01 covers the top quarter, code 10 the top half, code 11 the whole array, and code 00 covers nothing.
- R11: Kind 3 is permitted whatever wp_i and the block-lock code are. Kind 4 is denied while wp_i is 1.
- R12: Request kinds 5 to 7 are never permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write-protect pin, high blocks nonvolatile writes |
| reg_wr_i | input | 1 | Register write strobe, one cycle per byte |
| reg_wdata_i | input | 8 | Register write data |
| reg_rd_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Register byte returned by a read |
| rd_vld_o | output | 1 | High for one cycle when rd_data_o holds a read result |
| req_kind_i | input | 3 | Kind of write being asked about |
| req_addr_i | input | ADDR_W (9) | Memory target address for kind 2 |
| permit_o | output | 1 | Requested write is allowed |

## Verification
The decision logic is swept over all eight combinations of the protect pin and block-lock code. Each combination asks every request kind, and memory requests are asked at both the lowest and the highest address, so the sweep tells apart pin-driven denials from lock-driven ones and volatile permissions from nonvolatile ones. Directed sequences then try the unlock ladder in and out of order: 06h without a prior 02h, a read between unlock steps, a lock load while the pin is high, and an all-ones load that exposes the forced-zero bits. Memory addresses just below and at the quarter and half boundaries separate the three lock ranges, and the unused kind codes check that nothing outside the five kinds is permitted.

// File: rtl/wp_stat_pkg.sv
package wp_stat_pkg;

  typedef enum logic [2:0] {
    KIND_POT_VOL = 3'd0,
    KIND_POT_NV  = 3'd1,
    KIND_MEM     = 3'd2,
    KIND_REG_VOL = 3'd3,
    KIND_REG_NV  = 3'd4
  } wr_kind_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned WEL_BIT  = 1;
  localparam int unsigned RWEL_BIT = 2;
  localparam int unsigned BL_LO    = 3;
  localparam int unsigned BL_HI    = 4;
  localparam int unsigned BL_W     = BL_HI - BL_LO + 1;

  localparam logic [REG_W-1:0] CMD_SET_WEL  = 8'h02;
  localparam logic [REG_W-1:0] CMD_SET_RWEL = 8'h06;

endpackage

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wp_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             wel_o,
  output logic             rwel_o,
  output logic [BL_W-1:0]  bl_o
);

  logic            wel_q, rwel_q;
  logic [BL_W-1:0] bl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      bl_q   <= '0;
    end else if (wr_i) begin
      if (rwel_q) begin
        // armed: this byte is the register load
        wel_q  <= wdata_i[WEL_BIT];
        rwel_q <= 1'b0;
        if (!wp_i) bl_q <= wdata_i[BL_HI:BL_LO];
      end else if (wdata_i == CMD_SET_WEL) begin
        wel_q <= 1'b1;
      end else if (wdata_i == CMD_SET_RWEL && wel_q) begin
        rwel_q <= 1'b1;
      end
    end
  end

  assign wel_o  = wel_q;
  assign rwel_o = rwel_q;
  assign bl_o   = bl_q;

endmodule

// File: rtl/wp_lock_range.sv
module wp_lock_range
  import wp_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [BL_W-1:0]   bl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(DEPTH / 2);

  always_comb begin
    unique case (bl_i)
      2'b00:   locked_o = 1'b0;
      2'b01:   locked_o = (addr_i >= QTR_BASE);
      2'b10:   locked_o = (addr_i >= HALF_BASE);
      default: locked_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/wp_permit_dec.sv
module wp_permit_dec
  import wp_stat_pkg::*;
(
  input  logic            wp_i,
  input  logic            wel_i,
  input  logic            rwel_i,
  input  logic [BL_W-1:0] bl_i,
  input  logic            in_lock_i,
  input  logic [2:0]      kind_i,
  output logic            permit_o
);

  logic lock_on;
  assign lock_on = |bl_i;

  always_comb begin
    unique case (kind_i)
      KIND_POT_VOL: permit_o = wel_i & ~lock_on;
      KIND_POT_NV:  permit_o = wel_i & ~lock_on & ~wp_i;
      KIND_MEM:     permit_o = wel_i & ~wp_i & ~in_lock_i;
      KIND_REG_VOL: permit_o = rwel_i;
      KIND_REG_NV:  permit_o = rwel_i & ~wp_i;
      default:      permit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wp_stat_ctrl.sv
module wp_stat_ctrl
  import wp_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              permit_o
);

  logic            wel_q, rwel_q, in_lock;
  logic [BL_W-1:0] bl_q;
  logic [7:0]      stat_byte;

  wp_unlock_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wp_i   (wp_i),
    .wr_i   (reg_wr_i),
    .wdata_i(reg_wdata_i),
    .wel_o  (wel_q),
    .rwel_o (rwel_q),
    .bl_o   (bl_q)
  );

  wp_lock_range #(.ADDR_W(ADDR_W)) u_range (
    .bl_i    (bl_q),
    .addr_i  (req_addr_i),
    .locked_o(in_lock)
  );

  wp_permit_dec u_dec (
    .wp_i     (wp_i),
    .wel_i    (wel_q),
    .rwel_i   (rwel_q),
    .bl_i     (bl_q),
    .in_lock_i(in_lock),
    .kind_i   (req_kind_i),
    .permit_o (permit_o)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[WEL_BIT]     = wel_q;
    stat_byte[RWEL_BIT]    = rwel_q;
    stat_byte[BL_HI:BL_LO] = bl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
    end else begin
      rd_vld_o <= reg_rd_i;
      if (reg_rd_i) rd_data_o <= stat_byte;
    end
  end

endmodule

// File: rtl/wp_stat_ctrl_chk.sv
module wp_stat_ctrl_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wp_i,
  input logic        reg_wr_i,
  input logic [7:0]  reg_wdata_i,
  input logic [7:0]  rd_data_o,
  input logic        rd_vld_o,
  input logic [2:0]  req_kind_i,
  input logic        permit_o,
  input logic        wel_i,
  input logic        rwel_i,
  input logic [1:0]  bl_i
);

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_i |-> wel_i); // R3

  AST_RWEL_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !rwel_i && wel_i && reg_wdata_i == 8'h06) |=> rwel_i); // R3

  AST_LOAD_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && rwel_i) |=> !rwel_i); // R4

  AST_WP_HOLDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && wp_i) |=> $stable(bl_i)); // R5

  AST_RD_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> (rd_data_o[7:5] == 3'b000 && !rd_data_o[0])); // R6

  AST_WEL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wel_i && req_kind_i <= 3'd2) |-> !permit_o); // R7

  AST_RWEL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rwel_i && (req_kind_i == 3'd3 || req_kind_i == 3'd4)) |-> !permit_o); // R8

  AST_WP_NV_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && (req_kind_i == 3'd1 || req_kind_i == 3'd2 || req_kind_i == 3'd4)) |-> !permit_o); // R10

  AST_BAD_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i >= 3'd5) |-> !permit_o); // R12

endmodule

bind wp_stat_ctrl wp_stat_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_i       (wp_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .rd_data_o  (rd_data_o),
  .rd_vld_o   (rd_vld_o),
  .req_kind_i (req_kind_i),
  .permit_o   (permit_o),
  .wel_i      (wel_q),
  .rwel_i     (rwel_q),
  .bl_i       (bl_q)
);

// File: tb/wp_stat_ctrl_bench.sv
`timescale 1ns/1ps
module wp_stat_ctrl_bench;

  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  // index {wp, bl1, bl0}; bits: 5 mem@top, 4 reg nv, 3 reg vol, 2 mem@0, 1 pot nv, 0 pot vol
  localparam logic [5:0] PERM_TBL [8] = '{
    6'b111111, 6'b011100, 6'b011100, 6'b011000,
    6'b001001, 6'b001000, 6'b001000, 6'b001000
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wp = 1'b0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic              reg_rd = 1'b0;
  logic [7:0]        rd_data;
  logic              rd_vld;
  logic [2:0]        req_kind = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              permit;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  wp_stat_ctrl #(.ADDR_W(ADDR_W)) u_wp_stat_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wp_i       (wp),
    .reg_wr_i   (reg_wr),
    .reg_wdata_i(reg_wdata),
    .reg_rd_i   (reg_rd),
    .rd_data_o  (rd_data),
    .rd_vld_o   (rd_vld),
    .req_kind_i (req_kind),
    .req_addr_i (req_addr),
    .permit_o   (permit)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] exp);
    @(negedge clk);
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, {rd_vld, rd_data}, {1'b1, exp});
  endtask

  task automatic ask(input string tag, input logic [2:0] kind,
                     input logic [ADDR_W-1:0] addr, input logic exp);
    req_kind = kind; req_addr = addr;
    #1;
    chk(tag, {8'h0, permit}, {8'h0, exp});
  endtask

  // leaves WEL=1, RWEL=1, lock code bl (pin forced low while loading)
  task automatic set_lock(input logic [1:0] bl);
    wp = 1'b0;
    wr_byte(8'h02);
    wr_byte(8'h02);
    wr_byte(8'h06);
    wr_byte({3'b000, bl, 3'b010});
    wr_byte(8'h06);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R7 gating before WEL
    chk("R1 rd_vld after reset", {8'h0, rd_vld}, 9'h0);
    ask("R7 pot vol without WEL", 3'd0, '0, 1'b0);
    ask("R7 mem without WEL", 3'd2, '0, 1'b0);
    rd_check("R1 reset read", 8'h00);

    // R3 arm attempt without WEL is ignored
    wr_byte(8'h06);
    rd_check("R3 06h without WEL ignored", 8'h00);

    // R2 set WEL
    wr_byte(8'h02);
    rd_check("R2 02h sets WEL", 8'h02);
    ask("R8 reg vol without RWEL", 3'd3, '0, 1'b0);
    ask("R8 reg nv without RWEL", 3'd4, '0, 1'b0);

    // R3 arm, R6 reads do not disturb
    wr_byte(8'h06);
    rd_check("R3 06h with WEL sets RWEL", 8'h06);
    rd_check("R6 second read keeps RWEL", 8'h06);

    // R6 all-ones load: pad bits read 0
    wr_byte(8'hFF);
    rd_check("R6 FFh load reads 1Ah", 8'h1A);

    // R5 lock load with pin high keeps lock code
    wr_byte(8'h06);
    wp = 1'b1;
    wr_byte(8'h02);
    rd_check("R5 wp high keeps BL", 8'h1A);
    wp = 1'b0;

    // R4 02h,06h,02h clears lock code
    wr_byte(8'h02);
    wr_byte(8'h06);
    wr_byte(8'h02);
    rd_check("R4 02/06/02 clears BL", 8'h02);

    // R4 load clearing WEL
    wr_byte(8'h06);
    wr_byte(8'h00);
    rd_check("R4 load 00h clears WEL", 8'h00);

    // R9 R10 R11 sweep of pin and lock code
    for (int i = 0; i < 8; i++) begin
      set_lock(i[1:0]);
      wp = i[2];
      rd_check("R6 sweep readback", {3'b000, i[1:0], 3'b110});
      ask("R9 pot vol",  3'd0, '0, PERM_TBL[i][0]);
      ask("R9 pot nv",   3'd1, '0, PERM_TBL[i][1]);
      ask("R10 mem low", 3'd2, '0, PERM_TBL[i][2]);
      ask("R11 reg vol", 3'd3, '0, PERM_TBL[i][3]);
      ask("R11 reg nv",  3'd4, '0, PERM_TBL[i][4]);
      ask("R10 mem top", 3'd2, ADDR_W'(DEPTH - 1), PERM_TBL[i][5]);
    end

    // R10 range boundaries
    set_lock(2'b01);
    ask("R10 qtr below", 3'd2, ADDR_W'(DEPTH - DEPTH / 4 - 1), 1'b1);
    ask("R10 qtr at",    3'd2, ADDR_W'(DEPTH - DEPTH / 4), 1'b0);
    ask("R10 qtr half",  3'd2, ADDR_W'(DEPTH / 2), 1'b1);
    set_lock(2'b10);
    ask("R10 half below", 3'd2, ADDR_W'(DEPTH / 2 - 1), 1'b1);
    ask("R10 half at",    3'd2, ADDR_W'(DEPTH / 2), 1'b0);

    // R12 unused kinds
    set_lock(2'b00);
    for (int k = 5; k < 8; k++) ask("R12 unused kind", 3'(k), '0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule